// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block moves data between memory locations on behalf of a set of independent channels (eight by default). Each channel holds a source address, a destination address, a chain pointer, a control word and a configuration word. A single engine walks the channel indices in ascending order, one per cycle. When it finds a channel that may move data, it copies one element: a read from the source address and then a write to the destination address, over a 32-bit memory master port that uses a request/ready handshake. After the write it reduces the channel's remaining count.

When a channel's count reaches zero, one of two things happens. If its chain pointer is nonzero, the engine fetches the next descriptor from memory and the channel carries on. If the pointer is zero, the engine turns the channel off. Peripheral request lines can gate each element according to a flow code held in the channel's configuration word. A terminal-count pulse reports a finished block. An error response from memory shuts the channel down and raises an error pulse.

Channel registers are loaded through a simple write port. Software or a controller programs a channel and then sets its enable bit.

Top module: `dma_ll_engine`

## Requirements
- R1: After reset every channel enable output is 0, `mem_req` is 0, and no terminal-count or error pulse is asserted.
- R2: A channel starts a transfer only when all of these hold: its configuration bit 0 (enable) is 1, its configuration bit 18 (halt) is 0, its count is nonzero and `glb_en` is 1. Otherwise the memory port stays idle for that channel.
- R3: The gating vector is `preq_single | preq_burst`. The configuration word carries a source ID in bits [5:1], a destination ID in bits [10:6] and a flow code in bits [13:11]. Flow code 0 always transfers. Code 1 needs the gating bit named by the destination ID. Code 2 needs the bit named by the source ID. Code 3 needs both bits. Codes 4 to 7 never transfer.
- R4: Each element is a read of the source byte address followed by a write to the destination byte address. The element size is 1 << w bytes, where w is control bits [20:18] and codes above 2 act as 2. The read element is taken from the byte lanes selected by the source address bits [1:0]. The write places that element on the lanes selected by the destination address bits [1:0] and sets `mem_be` to the matching byte lanes.
- R5: After each element, the source address grows by the element size when control bit 26 is 1. The destination address grows by the element size when control bit 27 is 1. Otherwise the address stays the same.
- R6: The count is held in control bits [11:0]. The engine moves exactly that many elements and keeps the other control bits.
- R7: When the count reaches zero and the chain pointer is nonzero, the engine reads four words from the pointer address P. It loads the source from P, the destination from P+4, the new pointer from P+8 and the control word from P+12, and then keeps serving the channel.
- R8: When the count reaches zero and the chain pointer is zero, the channel's enable bit clears.
- R9: When a count reaches zero and control bit 31 of that block was 1, the channel's `tc_pulse` bit is high for exactly one cycle. No pulse is raised when bit 31 was 0.
- R10: An error response on any access clears the channel's enable bit and raises its `err_pulse` bit for one cycle. That channel makes no further access.
- R11: While `mem_req` is high and `mem_ready` is low, the address and direction hold steady.
- R12: With `cfg_we` high, `cfg_wdata` is written into channel `cfg_ch`. The register is chosen by `cfg_sel`: 0 source, 1 destination, 2 pointer, 3 control, 4 configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global engine enable |
| cfg_we | input | 1 | Channel register write strobe |
| cfg_ch | input | log2(NCH) (3) | Channel selected for the write |
| cfg_sel | input | 3 | Register selected for the write |
| cfg_wdata | input | 32 | Write data |
| preq_single | input | 32 | Single-element peripheral requests |
| preq_burst | input | 32 | Burst peripheral requests (used for gating only) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, word at the address with bits [1:0] cleared |
| mem_err | input | 1 | Error response, valid with mem_ready |
| chan_en | output | NCH (8) | Enable bit of each channel |
| tc_pulse | output | NCH (8) | Terminal-count pulses |
| err_pulse | output | NCH (8) | Error pulses |

## Verification
A read request appears the cycle after the scan reaches an eligible channel. The write request follows in the cycle after the read is accepted. Descriptor reads follow back to back after the last write. Enable clearing and the terminal-count and error pulses are visible in the cycle after the handshake that causes them. For each scenario, the bench's behavioural model builds the expected list of accesses. The memory responder checks each access at the falling edge where it raises `mem_ready`, and so it also catches any access that was not expected while gating or halting should block traffic. Pulses are counted at every falling edge, and enable bits are sampled one falling edge after the final handshake.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int PREQ_W    = 32;
    localparam int CNT_W     = 12;
    localparam int SW_LSB    = 18;
    localparam int SINC_BIT  = 26;
    localparam int DINC_BIT  = 27;
    localparam int TCI_BIT   = 31;
    localparam int EN_BIT    = 0;
    localparam int SID_LSB   = 1;
    localparam int DID_LSB   = 6;
    localparam int FLOW_LSB  = 11;
    localparam int HALT_BIT  = 18;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_LINK = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_CONF = 3'd4;

    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_LINK = 2'd3
    } dma_st_e;
endpackage

// File: rtl/dma_gate.sv
module dma_gate
    import dma_pkg::*;
(
    input  logic              glb_en,
    input  logic              ch_on,
    input  logic              ch_halt,
    input  logic [4:0]        sid,
    input  logic [4:0]        did,
    input  logic [2:0]        flow,
    input  logic              cnt_nz,
    input  logic [PREQ_W-1:0] preq,
    output logic              go
);
    logic s_hit, d_hit, flow_ok;

    assign s_hit = preq[sid];
    assign d_hit = preq[did];

    always_comb begin
        case (flow)
            3'd0:    flow_ok = 1'b1;
            3'd1:    flow_ok = d_hit;
            3'd2:    flow_ok = s_hit;
            3'd3:    flow_ok = s_hit & d_hit;
            default: flow_ok = 1'b0;
        endcase
    end

    assign go = glb_en & ch_on & ~ch_halt & cnt_nz & flow_ok;
endmodule

// File: rtl/dma_lane.sv
module dma_lane (
    input  logic [1:0]  wcode,
    input  logic [1:0]  src_off,
    input  logic [1:0]  dst_off,
    input  logic [31:0] rdata,
    input  logic [31:0] elem_in,
    output logic [31:0] elem_out,
    output logic [31:0] wdata,
    output logic [3:0]  be
);
    logic [31:0] mask;
    logic [3:0]  lanes;

    always_comb begin
        case (wcode)
            2'd0:    begin mask = 32'h0000_00ff; lanes = 4'b0001; end
            2'd1:    begin mask = 32'h0000_ffff; lanes = 4'b0011; end
            default: begin mask = 32'hffff_ffff; lanes = 4'b1111; end
        endcase
    end

    assign elem_out = (rdata >> {src_off, 3'b000}) & mask;
    assign wdata    = elem_in << {dst_off, 3'b000};
    assign be       = lanes << dst_off;
endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
    import dma_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [PREQ_W-1:0] preq_single,
    input  logic [PREQ_W-1:0] preq_burst,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic [NCH-1:0]    chan_en,
    output logic [NCH-1:0]    tc_pulse,
    output logic [NCH-1:0]    err_pulse
);
    typedef struct packed {
        dma_st_e                st;
        logic [IDX_W-1:0]       idx;
        logic [1:0]             k;
        logic [31:0]            base;
        logic [31:0]            elem;
        logic [NCH-1:0][31:0]   src;
        logic [NCH-1:0][31:0]   dst;
        logic [NCH-1:0][31:0]   link;
        logic [NCH-1:0][31:0]   ctrl;
        logic [NCH-1:0][31:0]   conf;
        logic [NCH-1:0]         tc;
        logic [NCH-1:0]         err;
    } eng_t;

    eng_t r_q, r_d;

    logic [PREQ_W-1:0] preq;
    logic [NCH-1:0]    elig;
    logic [1:0]        wcode;
    logic [31:0]       step;
    logic [CNT_W-1:0]  cnt_left;
    logic [31:0]       lane_elem, lane_wdata;
    logic [3:0]        lane_be;
    logic              fail;

    assign preq = preq_single | preq_burst;

    for (genvar g = 0; g < NCH; g++) begin : g_gate
        dma_gate u_gate (
            .glb_en (glb_en),
            .ch_on  (r_q.conf[g][EN_BIT]),
            .ch_halt(r_q.conf[g][HALT_BIT]),
            .sid    (r_q.conf[g][SID_LSB +: 5]),
            .did    (r_q.conf[g][DID_LSB +: 5]),
            .flow   (r_q.conf[g][FLOW_LSB +: 3]),
            .cnt_nz (r_q.ctrl[g][CNT_W-1:0] != '0),
            .preq   (preq),
            .go     (elig[g])
        );
        assign chan_en[g] = r_q.conf[g][EN_BIT];
    end

    assign wcode    = (r_q.ctrl[r_q.idx][SW_LSB +: 3] > 3'd2) ? 2'd2
                    : r_q.ctrl[r_q.idx][SW_LSB +: 2];
    assign step     = 32'd1 << wcode;
    assign cnt_left = r_q.ctrl[r_q.idx][CNT_W-1:0] - 1'b1;

    dma_lane u_lane (
        .wcode   (wcode),
        .src_off (r_q.src[r_q.idx][1:0]),
        .dst_off (r_q.dst[r_q.idx][1:0]),
        .rdata   (mem_rdata),
        .elem_in (r_q.elem),
        .elem_out(lane_elem),
        .wdata   (lane_wdata),
        .be      (lane_be)
    );

    assign fail = mem_req & mem_ready & mem_err;

    always_comb begin
        r_d     = r_q;
        r_d.tc  = '0;
        r_d.err = '0;
        case (r_q.st)
            ST_SCAN: begin
                if (elig[r_q.idx]) r_d.st = ST_RD;
                else r_d.idx = (r_q.idx == IDX_W'(NCH-1)) ? '0 : r_q.idx + 1'b1;
            end
            ST_RD: begin
                if (mem_ready && !mem_err) begin
                    r_d.elem = lane_elem;
                    r_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready && !mem_err) begin
                    if (r_q.ctrl[r_q.idx][SINC_BIT]) r_d.src[r_q.idx] = r_q.src[r_q.idx] + step;
                    if (r_q.ctrl[r_q.idx][DINC_BIT]) r_d.dst[r_q.idx] = r_q.dst[r_q.idx] + step;
                    r_d.ctrl[r_q.idx][CNT_W-1:0] = cnt_left;
                    r_d.st = ST_SCAN;
                    if (cnt_left == '0) begin
                        r_d.tc[r_q.idx] = r_q.ctrl[r_q.idx][TCI_BIT];
                        if (r_q.link[r_q.idx] != '0) begin
                            r_d.base = r_q.link[r_q.idx];
                            r_d.k    = 2'd0;
                            r_d.st   = ST_LINK;
                        end else begin
                            r_d.conf[r_q.idx][EN_BIT] = 1'b0;
                        end
                    end
                end
            end
            ST_LINK: begin
                if (mem_ready && !mem_err) begin
                    case (r_q.k)
                        2'd0:    r_d.src[r_q.idx]  = mem_rdata;
                        2'd1:    r_d.dst[r_q.idx]  = mem_rdata;
                        2'd2:    r_d.link[r_q.idx] = mem_rdata;
                        default: r_d.ctrl[r_q.idx] = mem_rdata;
                    endcase
                    r_d.k = r_q.k + 1'b1;
                    if (r_q.k == 2'd3) r_d.st = ST_SCAN;
                end
            end
            default: r_d.st = ST_SCAN;
        endcase
        if (fail) begin
            r_d.conf[r_q.idx][EN_BIT] = 1'b0;
            r_d.err[r_q.idx]          = 1'b1;
            r_d.st                    = ST_SCAN;
        end
        if (cfg_we) begin
            case (cfg_sel)
                SEL_SRC:  r_d.src[cfg_ch]  = cfg_wdata;
                SEL_DST:  r_d.dst[cfg_ch]  = cfg_wdata;
                SEL_LINK: r_d.link[cfg_ch] = cfg_wdata;
                SEL_CTRL: r_d.ctrl[cfg_ch] = cfg_wdata;
                SEL_CONF: r_d.conf[cfg_ch] = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_SCAN;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req   = (r_q.st != ST_SCAN);
        mem_we    = (r_q.st == ST_WR);
        mem_wdata = mem_we ? lane_wdata : '0;
        mem_be    = mem_we ? lane_be : 4'hf;
        case (r_q.st)
            ST_RD:   mem_addr = r_q.src[r_q.idx];
            ST_WR:   mem_addr = r_q.dst[r_q.idx];
            ST_LINK: mem_addr = r_q.base + {28'd0, r_q.k, 2'b00};
            default: mem_addr = '0;
        endcase
    end

    assign tc_pulse  = r_q.tc;
    assign err_pulse = r_q.err;

    // R11: request held steady until accepted
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R2: a new access only starts after a cycle with the global enable high
    a_r2_start_needs_glb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(glb_en));

    // R9: at most one terminal-count pulse at a time
    a_r9_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_pulse));

    // R4: a write always carries at least one byte lane
    a_r4_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_be != 4'h0));

    for (genvar e = 0; e < NCH; e++) begin : g_err_chk
        // R10: an error pulse comes with the channel switched off
        a_r10_err_disables: assert property (@(posedge clk) disable iff (!rst_n)
            err_pulse[e] |-> !chan_en[e]);
    end
endmodule

// File: tb/test_dma_ll_engine.sv
module test_dma_ll_engine;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] preq_single = '0;
    logic [31:0] preq_burst = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic [NCH-1:0] chan_en, tc_pulse, err_pulse;

    always #5 clk = ~clk;

    dma_ll_engine #(.NCH(NCH)) i_dma_ll_engine (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .preq_single(preq_single), .preq_burst(preq_burst),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .chan_en(chan_en), .tc_pulse(tc_pulse), .err_pulse(err_pulse)
    );

    int checks = 0;
    int fails = 0;
    int acc_cnt = 0;
    int cycles = 0;
    string cur = "R1";
    logic [31:0] err_addr = 32'hffff_fff0;
    logic [31:0] mem [logic [31:0]];
    int exp_tc [NCH];
    int exp_err [NCH];
    int tc_seen [NCH];
    int err_seen [NCH];
    logic        q_we [$];
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    logic [3:0]  q_be [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[15:0] ^ 16'h5a5a, ~a[15:0]};
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_be.push_back(be);
    endtask

    // behavioural model of one channel's whole chain
    task automatic model(input int ch, input logic [31:0] s0, input logic [31:0] d0,
                         input logic [31:0] l0, input logic [31:0] c0);
        logic [31:0] s, d, l, c, rw, el, m;
        logic [3:0]  b;
        int w;
        s = s0; d = d0; l = l0; c = c0;
        forever begin
            w = (c[20:18] > 3'd2) ? 2 : int'(c[20:18]);
            m = (w == 0) ? 32'hff : (w == 1) ? 32'hffff : 32'hffff_ffff;
            b = (w == 0) ? 4'h1 : (w == 1) ? 4'h3 : 4'hf;
            for (int i = 0; i < int'(c[11:0]); i++) begin
                rw = rd_word({s[31:2], 2'b00});
                el = (rw >> (8 * int'(s[1:0]))) & m;
                push(1'b0, s, '0, 4'hf);
                push(1'b1, d, el << (8 * int'(d[1:0])), 4'(b << d[1:0]));
                if (c[26]) s = s + (32'd1 << w);
                if (c[27]) d = d + (32'd1 << w);
            end
            if (c[31]) exp_tc[ch]++;
            if (l == '0) break;
            push(1'b0, l, '0, 4'hf); push(1'b0, l + 4, '0, 4'hf);
            push(1'b0, l + 8, '0, 4'hf); push(1'b0, l + 12, '0, 4'hf);
            s = rd_word(l); d = rd_word(l + 4); c = rd_word(l + 12); l = rd_word(l + 8);
        end
    endtask

    task automatic serve();
        logic [31:0] m;
        acc_cnt++;
        if (q_addr.size() == 0) begin
            chk(1'b0, {cur, " unexpected access"}, mem_addr, 32'h0);
        end else begin
            logic we_e; logic [31:0] a_e, d_e; logic [3:0] be_e;
            we_e = q_we.pop_front(); a_e = q_addr.pop_front();
            d_e = q_data.pop_front(); be_e = q_be.pop_front();
            chk(mem_we == we_e, {cur, " direction"}, {31'd0, mem_we}, {31'd0, we_e});
            chk(mem_addr == a_e, {cur, " address"}, mem_addr, a_e);
            if (we_e) begin
                m = lane_mask(be_e);
                chk(mem_be == be_e, {cur, " R4 byte enables"}, {28'd0, mem_be}, {28'd0, be_e});
                chk((mem_wdata & m) == (d_e & m), {cur, " R4 write data"}, mem_wdata & m, d_e & m);
            end
        end
        mem_err = (mem_addr == err_addr);
        if (mem_we && !mem_err) begin
            m = lane_mask(mem_be);
            mem[{mem_addr[31:2], 2'b00}] = (rd_word({mem_addr[31:2], 2'b00}) & ~m) | (mem_wdata & m);
        end
        mem_rdata = rd_word({mem_addr[31:2], 2'b00});
        mem_ready = 1'b1;
    endtask

    // memory responder with 0..2 wait cycles
    initial begin
        int lat = 0;
        int lc = 0;
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            mem_err = 1'b0;
            if (rst_n && mem_req) begin
                if (lc < lat) lc++;
                else begin
                    lc = 0;
                    lat = (lat + 1) % 3;
                    serve();
                end
            end else lc = 0;
        end
    end

    // pulse counters and watchdog
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            for (int i = 0; i < NCH; i++) begin
                tc_seen[i] += int'(tc_pulse[i]);
                err_seen[i] += int'(err_pulse[i]);
            end
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired in %s actual %0d expected 150000", cur, cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    task automatic cfg(input int ch, input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] l, input logic [31:0] c, input logic [31:0] f);
        cfg(ch, 3'd3, c); cfg(ch, 3'd0, s); cfg(ch, 3'd1, d); cfg(ch, 3'd2, l); cfg(ch, 3'd4, f);
    endtask

    task automatic wait_idle(input int ch);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!chan_en[ch] && q_addr.size() == 0) break;
        end
        repeat (2) @(negedge clk);
        chk(q_addr.size() == 0, {cur, " all expected accesses made"}, q_addr.size(), 0);
        chk(!chan_en[ch], {cur, " R8 enable cleared at end"}, {31'd0, chan_en[ch]}, 32'd0);
        chk(tc_seen[ch] == exp_tc[ch], {cur, " R9 tc pulses"}, tc_seen[ch], exp_tc[ch]);
        chk(err_seen[ch] == exp_err[ch], {cur, " R10 error pulses"}, err_seen[ch], exp_err[ch]);
    endtask

    task automatic quiet(input int ch, input int n);
        int a0;
        a0 = acc_cnt;
        repeat (n) @(negedge clk);
        chk(acc_cnt == a0, {cur, " no access while blocked"}, acc_cnt, a0);
        chk(chan_en[ch], {cur, " R12 channel still enabled"}, {31'd0, chan_en[ch]}, 32'd1);
    endtask

    localparam logic [31:0] INC2 = (32'd1 << 26) | (32'd1 << 27);
    localparam logic [31:0] TCI  = 32'h8000_0000;

    initial begin
        logic [31:0] c;
        repeat (3) @(negedge clk);
        cur = "R1";
        chk(chan_en == '0, "R1 enables after reset", 32'(chan_en), 0);
        chk(!mem_req, "R1 no request after reset", {31'd0, mem_req}, 0);
        chk(tc_pulse == '0 && err_pulse == '0, "R1 no pulses after reset", 32'(tc_pulse | err_pulse), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        glb_en = 1'b1;

        // word elements, both addresses increment, tc enabled
        cur = "R6";
        c = TCI | INC2 | (32'd2 << 18) | 32'd4;
        model(0, 32'h1000, 32'h2000, 32'h0, c);
        prog(0, 32'h1000, 32'h2000, 32'h0, c, 32'h1);
        wait_idle(0);

        // byte elements at odd offsets, fixed destination, no tc
        cur = "R5";
        c = (32'd1 << 26) | 32'd3;
        model(1, 32'h1101, 32'h2202, 32'h0, c);
        prog(1, 32'h1101, 32'h2202, 32'h0, c, 32'h1);
        wait_idle(1);

        // halfword start then a two-descriptor chain (width code 7 acts as word)
        cur = "R7";
        mem[32'h3000] = 32'h1202; mem[32'h3004] = 32'h2302;
        mem[32'h3008] = 32'h3010; mem[32'h300c] = INC2 | (32'd7 << 18) | 32'd1;
        mem[32'h3010] = 32'h1300; mem[32'h3014] = 32'h2400;
        mem[32'h3018] = 32'h0;    mem[32'h301c] = TCI | INC2 | 32'd2;
        c = TCI | (32'd1 << 27) | (32'd1 << 18) | 32'd2;
        model(3, 32'h1002, 32'h2100, 32'h3000, c);
        prog(3, 32'h1002, 32'h2100, 32'h3000, c, 32'h1);
        wait_idle(3);

        // halted channel is skipped until the halt bit is cleared
        cur = "R2";
        c = INC2 | (32'd2 << 18) | 32'd2;
        prog(2, 32'h1500, 32'h2500, 32'h0, c, 32'h1 | (32'd1 << 18));
        quiet(2, 40);
        model(2, 32'h1500, 32'h2500, 32'h0, c);
        cfg(2, 3'd4, 32'h1);
        wait_idle(2);

        // global enable low blocks all traffic
        glb_en = 1'b0;
        prog(2, 32'h1600, 32'h2600, 32'h0, c, 32'h1);
        quiet(2, 40);
        model(2, 32'h1600, 32'h2600, 32'h0, c);
        glb_en = 1'b1;
        wait_idle(2);

        // flow code 1: destination id 7 via the burst request
        cur = "R3";
        c = INC2 | 32'd2;
        prog(4, 32'h1700, 32'h2700, 32'h0, c, 32'h1 | (32'd7 << 6) | (32'd1 << 11));
        quiet(4, 40);
        model(4, 32'h1700, 32'h2700, 32'h0, c);
        preq_burst = 32'h80;
        wait_idle(4);
        preq_burst = '0;

        // flow code 2: source id 9 via the single request
        prog(4, 32'h1800, 32'h2800, 32'h0, c, 32'h1 | (32'd9 << 1) | (32'd2 << 11));
        quiet(4, 40);
        model(4, 32'h1800, 32'h2800, 32'h0, c);
        preq_single = 32'h200;
        wait_idle(4);
        preq_single = '0;

        // flow code 3: source 3 and destination 12 both needed
        prog(4, 32'h1900, 32'h2900, 32'h0, c, 32'h1 | (32'd3 << 1) | (32'd12 << 6) | (32'd3 << 11));
        preq_single = 32'h8;
        quiet(4, 40);
        model(4, 32'h1900, 32'h2900, 32'h0, c);
        preq_burst = 32'h1000;
        wait_idle(4);
        preq_single = '0; preq_burst = '0;

        // flow code 5 never transfers, even with every request high
        preq_single = '1;
        prog(4, 32'h1a00, 32'h2a00, 32'h0, c, 32'h1 | (32'd5 << 11));
        quiet(4, 40);
        preq_single = '0;
        model(4, 32'h1a00, 32'h2a00, 32'h0, c);
        cfg(4, 3'd4, 32'h1);
        wait_idle(4);

        // error on the second write stops the channel
        cur = "R10";
        c = TCI | INC2 | (32'd2 << 18) | 32'd3;
        err_addr = 32'h2b04;
        model(5, 32'h1b00, 32'h2b00, 32'h0, c);
        exp_tc[5] = 0;
        while (q_addr.size() > 4) begin
            void'(q_we.pop_back()); void'(q_addr.pop_back());
            void'(q_data.pop_back()); void'(q_be.pop_back());
        end
        exp_err[5] = 1;
        prog(5, 32'h1b00, 32'h2b00, 32'h0, c, 32'h1);
        wait_idle(5);
        chk(mem.exists(32'h2b00) && mem[32'h2b00] == rd_word(32'h1b00), "R10 first element landed",
            rd_word(32'h2b00), rd_word(32'h1b00));
        repeat (30) @(negedge clk);
        chk(q_addr.size() == 0 && !mem_req, "R10 no access after error", {31'd0, mem_req}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule